// File: doc/BRIEF.md
# Key-Locked Configuration Register Guard

This block sits on a byte-wide synchronous register bus. It holds six 8-bit clock configuration registers and one protection register that guards them. The protection register keeps a single lock flag. Storing the unlock key 0x26 into it clears the flag. Storing any other byte sets the flag. While the flag is set, bus writes aimed at the six configuration registers are dropped without any change. Reads of those registers still return the stored contents. A rejected write produces a one-cycle `write_blocked` pulse.

A write takes effect on the rising clock edge where `wr_en` is high. `rdata` is a combinational view of the register selected by `addr`. Configuration register k sits at address k, for k from 0 to 5. The protection register sits at address 7. Every other address is unmapped. The stored configuration bytes are presented on `cfg_q` for the clock hardware, which is not part of this block. Reset is synchronous and active low.

Top module: `cfg_guard_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge forces the lock flag to 0, `write_blocked` to 0, and configuration register k to byte k of the `RST_VALS` parameter (`cfg_q[8k+7:8k]`). This holds even when a write is presented in the same cycle. The default is 0x00, 0x01, 0x80, 0x41, 0x10, 0x0F for k = 0..5.
- R2: A write of exactly 0x26 to address 7 leaves the lock flag at 0 after that edge.
- R3: A write of any value other than 0x26 to address 7 leaves the lock flag at 1 after that edge. This includes values one away from the key and 0x00.
- R4: While the lock flag is 1, a write to an address in 0..5 leaves all six configuration registers unchanged.
- R5: While the lock flag is 0, a write to address k in 0..5 stores `wdata` into register k only. The new value appears on `cfg_q` and `rdata` after that edge.
- R6: A read of address k in 0..5 returns register k, whatever the state of the lock flag.
- R7: A read of address 7 returns the lock flag in bit 0 and zero in bits 7 to 1.
- R8: `write_blocked` is 1 in exactly the cycle after an edge that dropped a write under R4, and 0 otherwise. A dropped write leaves the lock flag unchanged.
- R9: Addresses 6 and 8 to 15 read as 0x00. A write to them changes no register and does not change the lock flag.
- R10: A write to address 7 is never blocked. Writing 0x26 while the flag is 1 clears it.
- R11: `prot_active` always equals the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cfg_q | output | 48 | Six configuration bytes, register k in bits 8k+7:8k |
| prot_active | output | 1 | Current lock flag |
| write_blocked | output | 1 | One-cycle pulse after a rejected configuration write |

## Verification
The lock register is driven with the key, with neighbours of the key (0x25, 0x27), and with 0x00, 0xFF and arbitrary bytes. These separate an exact-match compare from a masked or range compare, and show that the flag cannot hold ordinary data. Configuration writes are tried in both lock states, including back-to-back rejected writes and an unlock while locked. This shows that the guard drops exactly the guarded writes, that the pulse does not stretch, and that the lock register itself is never blocked. Unmapped addresses and a long stretch of random traffic, which is biased toward the key, are compared each cycle against a behavioural model of all six registers and the flag. This catches decode aliasing and writes that land in the wrong register.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_CFG = 6;
  localparam int CFG_W   = NUM_CFG * DATA_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t PROT_ADDR  = addr_t'(7);
  localparam byte_t UNLOCK_KEY = byte_t'(8'h26);

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CFG  = 2'd1,
    ACC_PROT = 2'd2
  } acc_kind_e;

  // address k in [0, NUM_CFG) selects configuration register k
  function automatic logic is_cfg_addr(addr_t a);
    return int'(a) < NUM_CFG;
  endfunction

  function automatic acc_kind_e classify(addr_t a);
    if (is_cfg_addr(a))  return ACC_CFG;
    if (a == PROT_ADDR)  return ACC_PROT;
    return ACC_NONE;
  endfunction

  // next lock flag for a write to the protection register
  function automatic logic lock_next(byte_t d);
    return (d == UNLOCK_KEY) ? 1'b0 : 1'b1;
  endfunction

  // read view of the protection register
  function automatic byte_t prot_view(logic flag);
    return {{(DATA_W-1){1'b0}}, flag};
  endfunction

endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode
  import cfg_guard_pkg::*;
(
  input  addr_t                 addr,
  input  logic                  wr_en,
  output acc_kind_e             kind,
  output logic [NUM_CFG-1:0]    cfg_hit,
  output logic                  prot_wr
);

  always_comb kind = classify(addr);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_hit
    assign cfg_hit[k] = (addr == addr_t'(k));
  end

  assign prot_wr = wr_en && (kind == ACC_PROT);

endmodule

// File: rtl/cfg_guard_lock.sv
module cfg_guard_lock
  import cfg_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  prot_wr,
  input  byte_t wdata,
  output logic  lock_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (prot_wr) lock_q <= lock_next(wdata);
  end

endmodule

// File: rtl/cfg_guard_bank.sv
module cfg_guard_bank
  import cfg_guard_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VALS = '0
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CFG-1:0] wr_sel,
  input  byte_t              wdata,
  output logic [CFG_W-1:0]   cfg_q
);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_reg
    localparam byte_t RV = RST_VALS[k*DATA_W +: DATA_W];
    byte_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)         q <= RV;
      else if (wr_sel[k]) q <= wdata;
    end
    assign cfg_q[k*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top
  import cfg_guard_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VALS = 48'h0F_10_41_80_01_00
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [47:0]      cfg_q,
  output logic             prot_active,
  output logic             write_blocked
);

  acc_kind_e          kind;
  logic [NUM_CFG-1:0] cfg_hit;
  logic               prot_wr;
  logic               lock_q;

  // named internal events, observed by the checker
  logic               cfg_wr_req;
  logic               cfg_wr_accept;
  logic               cfg_wr_reject;
  logic [NUM_CFG-1:0] cfg_wr_sel;

  cfg_guard_decode u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .kind    (kind),
    .cfg_hit (cfg_hit),
    .prot_wr (prot_wr)
  );

  cfg_guard_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .prot_wr (prot_wr),
    .wdata   (wdata),
    .lock_q  (lock_q)
  );

  assign cfg_wr_req    = wr_en && (kind == ACC_CFG);
  assign cfg_wr_accept = cfg_wr_req && !lock_q;
  assign cfg_wr_reject = cfg_wr_req && lock_q;
  assign cfg_wr_sel    = cfg_wr_accept ? cfg_hit : '0;

  cfg_guard_bank #(.RST_VALS(RST_VALS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (cfg_wr_sel),
    .wdata  (wdata),
    .cfg_q  (cfg_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) write_blocked <= 1'b0;
    else        write_blocked <= cfg_wr_reject;
  end

  always_comb begin
    rdata = '0;
    unique case (kind)
      ACC_CFG:  rdata = cfg_q[int'(addr)*DATA_W +: DATA_W];
      ACC_PROT: rdata = prot_view(lock_q);
      default:  rdata = '0;
    endcase
  end

  assign prot_active = lock_q;

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
  import cfg_guard_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VALS = '0
)(
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic [47:0]      cfg_q,
  input logic             prot_active,
  input logic             write_blocked,
  input logic             cfg_wr_reject
);

  // R1: reset wins over any write in the same cycle
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!prot_active && !write_blocked && cfg_q == RST_VALS));

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PROT_ADDR && wdata == UNLOCK_KEY) |=> !prot_active);

  assert_other_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PROT_ADDR && wdata != UNLOCK_KEY) |=> prot_active);

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_active && wr_en && is_cfg_addr(addr)) |=> $stable(cfg_q));

  assert_open_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_active && wr_en && is_cfg_addr(addr)) |=>
      (cfg_q[int'($past(addr))*DATA_W +: DATA_W] == $past(wdata)));

  assert_prot_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == PROT_ADDR) |-> (rdata[7:1] == 7'd0 && rdata[0] == prot_active));

  assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_reject |=> write_blocked);

  assert_no_spurious_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(prot_active && wr_en && is_cfg_addr(addr)) |=> !write_blocked);

  assert_flag_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == PROT_ADDR) |=> $stable(prot_active));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_cfg_addr(addr) && addr != PROT_ADDR) |=> $stable(cfg_q));

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_cfg_addr(addr) && addr != PROT_ADDR) |-> rdata == 8'h00);

endmodule

bind cfg_guard_top cfg_guard_chk #(.RST_VALS(RST_VALS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .wr_en         (wr_en),
  .wdata         (wdata),
  .rdata         (rdata),
  .cfg_q         (cfg_q),
  .prot_active   (prot_active),
  .write_blocked (write_blocked),
  .cfg_wr_reject (cfg_wr_reject)
);

// File: tb/cfg_guard_top_test.sv
module cfg_guard_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] cfg_q;
  logic        prot_active;
  logic        write_blocked;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] m_cfg [6];
  logic       m_lock;
  logic       m_blk;
  logic [7:0] rst_bytes [6] = '{8'h00, 8'h01, 8'h80, 8'h41, 8'h10, 8'h0F};

  cfg_guard_top uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .cfg_q(cfg_q), .prot_active(prot_active),
    .write_blocked(write_blocked)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] model_cfg();
    logic [47:0] v = '0;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = m_cfg[k];
    return v;
  endfunction

  function automatic logic [7:0] model_read(logic [3:0] a);
    if (a < 6)  return m_cfg[a];
    if (a == 7) return {7'd0, m_lock};
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 6; k++) m_cfg[k] = rst_bytes[k];
    m_lock = 1'b0;
    m_blk  = 1'b0;
  endtask

  // R1: reset, with a write presented in the same cycle
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b1; addr = 4'd2; wdata = 8'hAA;
    @(posedge clk); #1;
    model_reset();
    check("R1", "cfg_q", cfg_q, model_cfg());
    check("R1", "prot_active", {47'd0, prot_active}, {47'd0, m_lock});
    check("R1", "write_blocked", {47'd0, write_blocked}, 48'd0);
    @(negedge clk);
    rst_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic bus_cycle(input logic [3:0] a, input logic we, input logic [7:0] d);
    string rtag, ctag, ptag;
    logic  was_locked;
    @(negedge clk);
    addr = a; wr_en = we; wdata = d;
    #2;
    rtag = (a < 6) ? "R6" : (a == 7) ? "R7" : "R9";
    check(rtag, "rdata", {40'd0, rdata}, {40'd0, model_read(a)});
    was_locked = m_lock;
    ctag = (!we) ? "R6" : (a < 6) ? (m_lock ? "R4" : "R5") : (a == 7) ? "R10" : "R9";
    ptag = (we && a == 7) ? ((d == 8'h26) ? (was_locked ? "R10" : "R2") : "R3") :
           (we && a != 7 && a >= 6) ? "R9" : "R8";
    // reference update
    m_blk = 1'b0;
    if (we) begin
      if (a == 7)     m_lock = (d == 8'h26) ? 1'b0 : 1'b1;
      else if (a < 6) begin
        if (m_lock) m_blk = 1'b1;
        else        m_cfg[a] = d;
      end
    end
    @(posedge clk); #1;
    check(ctag, "cfg_q", cfg_q, model_cfg());
    check(ptag, "prot_active", {47'd0, prot_active}, {47'd0, m_lock});
    check("R11", "flag readback", {47'd0, prot_active}, {47'd0, m_lock});
    check("R8", "write_blocked", {47'd0, write_blocked}, {47'd0, m_blk});
  endtask

  initial begin
    model_reset();
    do_reset();
    for (int k = 0; k < 16; k++) bus_cycle(4'(k), 1'b0, 8'h00);   // R1 / R6 / R9 reads
    for (int k = 0; k < 6; k++) bus_cycle(4'(k), 1'b1, 8'hC0 + 8'(k)); // R5
    bus_cycle(4'd7, 1'b1, 8'h26);          // R2 while open
    bus_cycle(4'd7, 1'b1, 8'h5A);          // R3
    bus_cycle(4'd7, 1'b0, 8'h00);          // R7
    bus_cycle(4'd3, 1'b1, 8'h99);          // R4 / R8
    bus_cycle(4'd3, 1'b1, 8'h98);          // back-to-back reject
    bus_cycle(4'd0, 1'b1, 8'h11);
    bus_cycle(4'd3, 1'b0, 8'h00);          // R6 under lock, pulse drops
    bus_cycle(4'd6, 1'b1, 8'h26);          // R9, not an unlock
    bus_cycle(4'd7, 1'b1, 8'h26);          // R10
    bus_cycle(4'd7, 1'b1, 8'h27);          // R3 near key
    bus_cycle(4'd7, 1'b1, 8'h26);
    bus_cycle(4'd7, 1'b1, 8'h25);          // R3 near key
    bus_cycle(4'd7, 1'b1, 8'h00);          // R3 zero
    bus_cycle(4'd7, 1'b1, 8'hFF);          // R3, R7 bits ignored
    bus_cycle(4'd7, 1'b0, 8'h00);
    bus_cycle(4'd7, 1'b1, 8'h26);
    for (int k = 8; k < 16; k++) bus_cycle(4'(k), 1'b1, 8'h3C);  // R9
    bus_cycle(4'd5, 1'b1, 8'h77);          // R5
    bus_cycle(4'd5, 1'b0, 8'h00);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      logic [7:0] d = ($urandom_range(0, 3) == 0) ? 8'h26 : 8'($urandom);
      if ($urandom_range(0, 2) == 0) a = 4'd7;
      bus_cycle(a, 1'($urandom_range(0, 1)), d);
    end
    do_reset();                            // R1 mid-run
    bus_cycle(4'd2, 1'b0, 8'h00);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule